// File: doc/BRIEF.md
# DMA Microcode Channel Engine

This block is one thread of a DMA channel that runs its own byte-coded program instead of a fixed descriptor. A program is written byte by byte into a small internal program memory. A start command then names the first byte of the program. From there the channel fetches instructions one byte per cycle and decodes their variable length. It loads its source address, destination address and channel-control registers from 32-bit immediates. It runs up to two nested hardware loops from 8-bit counters. It issues burst read and write requests on a simple valid/ready memory-request port.

A program finishes at an end instruction, and the channel then returns to idle. A send-event instruction raises a completion flag and an event number. The flag stays up until software clears it. An undefined opcode or an undefined register select parks the channel in a fault state with an abort output. Only the kill input brings it out of that state. Kill also abandons any outstanding request from any state.

Top module: `dma_ucode_channel`

## Requirements
- R1: After reset, status is 0 (idle), and mreq_valid, evt_flag and abort are all low.
- R2: A start pulse in the idle state begins fetching at start_pc. A start pulse in any other state has no effect on execution.
- R3: The move instruction is 0xBC, then a select byte, then a 32-bit immediate sent least significant byte first. The low 3 bits of the select byte pick the target: 0 for the source address, 1 for the channel control register, 2 for the destination address. Any other select value causes a fault.
- R4: 0x20 n loads loop counter 0 with n, and 0x22 n loads loop counter 1. 0x38 d closes loop 0 and 0x3C d closes loop 1. At a loop end, a nonzero counter is decremented and execution jumps to the loop end's own address minus d. A zero counter falls through. A loop therefore runs n+1 times, and n = 0xFF gives 256 iterations.
- R5: Opcode 0x04 issues one read request at the source address. Opcode 0x08 issues one write request at the destination address. The channel-control fields are: source increment bit 0, source size bits 3:1, source beats-minus-one bits 7:4, destination increment bit 14, destination size bits 17:15, destination beats-minus-one bits 21:18. mreq_beats_m1 and mreq_size carry the fields of the side being used.
- R6: A request stays valid with a stable address until mreq_ready. After acceptance, the address register of that side advances by (beats_m1+1)·2^size bytes if its increment bit is set, and stays the same otherwise.
- R7: Opcode 0x00 ends the program and returns status to 0.
- R8: 0x34 e sets evt_flag and drives evt_id to e. The flag holds until evt_clr. A send-event in the same cycle as evt_clr wins.
- R9: An undefined opcode puts status at 3 with abort high. The channel stays there, ignoring start, until kill.
- R10: Kill forces status to 0 in the next cycle from any state, drops mreq_valid and clears abort.
- R11: Status is 0 when idle, 1 while fetching or executing, 2 while a request waits for mreq_ready, and 3 when faulted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pm_we | input | 1 | Program memory write enable |
| pm_waddr | input | PAW | Program memory write address |
| pm_wdata | input | 8 | Program memory write byte |
| start | input | 1 | Start command |
| start_pc | input | PAW | First program byte for a start |
| kill | input | 1 | Terminate the thread |
| evt_clr | input | 1 | Clear the completion flag |
| mreq_valid | output | 1 | Memory request valid |
| mreq_write | output | 1 | 1 for a store (write), 0 for a load (read) |
| mreq_addr | output | 32 | Burst start address |
| mreq_beats_m1 | output | 4 | Beats in the burst minus one |
| mreq_size | output | 3 | Log2 of the beat size in bytes |
| mreq_ready | input | 1 | Request accepted |
| status | output | 2 | Channel state encoding |
| evt_flag | output | 1 | Completion event pending |
| evt_id | output | 8 | Number of the last event |
| abort | output | 1 | Fault pending |

## Verification
The bench builds the channel with the default PAW of 8, which gives a 256-byte program memory. At that size, programs can be placed at random bases so that both backward jumps and the full 256-iteration inner loop fit. Random programs with random control words cover every combination of increment bits, burst sizes and lengths. The memory side stalls at random, so requests are held across several cycles. Directed runs cover a stalled request being killed, an undefined opcode, a bad register select, a start that arrives while the channel is busy, and the priority between a clear and a new event.

// File: rtl/dma_ucode_channel.sv
module dma_ucode_channel #(
  parameter int PAW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pm_we,
  input  logic [PAW-1:0] pm_waddr,
  input  logic [7:0]     pm_wdata,
  input  logic           start,
  input  logic [PAW-1:0] start_pc,
  input  logic           kill,
  input  logic           evt_clr,
  output logic           mreq_valid,
  output logic           mreq_write,
  output logic [31:0]    mreq_addr,
  output logic [3:0]     mreq_beats_m1,
  output logic [2:0]     mreq_size,
  input  logic           mreq_ready,
  output logic [1:0]     status,
  output logic           evt_flag,
  output logic [7:0]     evt_id,
  output logic           abort
);
  localparam int DEPTH = 1 << PAW;
  localparam logic [PAW-1:0] ONE = 1;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_OPER, S_EXEC, S_WAIT, S_FAULT} st_t;

  st_t            st;
  logic [7:0]     pmem [DEPTH];
  logic [PAW-1:0] pc, ipc;
  logic [7:0]     op;
  logic [39:0]    opnd;
  logic [2:0]     rem;
  logic [31:0]    sar, dar, ccr;
  logic [7:0]     lc0, lc1;

  function automatic logic [2:0] op_len(input logic [7:0] o);
    case (o)
      8'hBC:                             op_len = 3'd6;
      8'h20, 8'h22, 8'h38, 8'h3C, 8'h34: op_len = 3'd2;
      8'h04, 8'h08, 8'h00:               op_len = 3'd1;
      default:                           op_len = 3'd0;
    endcase
  endfunction

  always_ff @(posedge clk)
    if (pm_we) pmem[pm_waddr] <= pm_wdata;

  wire [7:0]     cur     = pmem[pc];
  wire [2:0]     cur_len = op_len(cur);
  wire [7:0]     arg     = opnd[39:32];
  wire [PAW-1:0] back    = ipc - PAW'(arg);
  wire [31:0]    src_step = ({28'd0, ccr[7:4]} + 32'd1) << ccr[3:1];
  wire [31:0]    dst_step = ({28'd0, ccr[21:18]} + 32'd1) << ccr[17:15];

  assign mreq_valid    = (st == S_WAIT);
  assign mreq_write    = (op == 8'h08);
  assign mreq_addr     = mreq_write ? dar : sar;
  assign mreq_beats_m1 = mreq_write ? ccr[21:18] : ccr[7:4];
  assign mreq_size     = mreq_write ? ccr[17:15] : ccr[3:1];
  assign abort         = (st == S_FAULT);
  assign status        = (st == S_IDLE)  ? 2'd0 :
                         (st == S_WAIT)  ? 2'd2 :
                         (st == S_FAULT) ? 2'd3 : 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      pc       <= '0;
      ipc      <= '0;
      op       <= '0;
      opnd     <= '0;
      rem      <= '0;
      sar      <= '0;
      dar      <= '0;
      ccr      <= '0;
      lc0      <= '0;
      lc1      <= '0;
      evt_flag <= 1'b0;
      evt_id   <= '0;
    end else begin
      if (evt_clr) evt_flag <= 1'b0;
      if (kill) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            pc <= start_pc;
            st <= S_FETCH;
          end
          S_FETCH: begin
            op  <= cur;
            ipc <= pc;
            pc  <= pc + ONE;
            rem <= cur_len - 3'd1;
            if (cur_len == 3'd0)      st <= S_FAULT;
            else if (cur_len == 3'd1) st <= S_EXEC;
            else                      st <= S_OPER;
          end
          S_OPER: begin
            opnd <= {cur, opnd[39:8]};
            pc   <= pc + ONE;
            rem  <= rem - 3'd1;
            if (rem == 3'd1) st <= S_EXEC;
          end
          S_EXEC: begin
            st <= S_FETCH;
            case (op)
              8'hBC:
                case (opnd[2:0])
                  3'd0:    sar <= opnd[39:8];
                  3'd1:    ccr <= opnd[39:8];
                  3'd2:    dar <= opnd[39:8];
                  default: st  <= S_FAULT;
                endcase
              8'h20: lc0 <= arg;
              8'h22: lc1 <= arg;
              8'h38: if (lc0 != 8'd0) begin
                lc0 <= lc0 - 8'd1;
                pc  <= back;
              end
              8'h3C: if (lc1 != 8'd0) begin
                lc1 <= lc1 - 8'd1;
                pc  <= back;
              end
              8'h04, 8'h08: st <= S_WAIT;
              8'h34: begin
                evt_flag <= 1'b1;
                evt_id   <= arg;
              end
              default: st <= S_IDLE;
            endcase
          end
          S_WAIT: if (mreq_ready) begin
            if (mreq_write) begin
              if (ccr[14]) dar <= dar + dst_step;
            end else begin
              if (ccr[0]) sar <= sar + src_step;
            end
            st <= S_FETCH;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_ucode_channel_chk.sv
module dma_ucode_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        kill,
  input logic        evt_clr,
  input logic        mreq_valid,
  input logic        mreq_write,
  input logic [31:0] mreq_addr,
  input logic        mreq_ready,
  input logic [1:0]  status,
  input logic        evt_flag,
  input logic        abort
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> status == 2'd0 && !mreq_valid && !evt_flag && !abort);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status == 2'd0 && !start |=> status == 2'd0);

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready && !kill |=> mreq_valid && $stable(mreq_addr) && $stable(mreq_write));

  assert_evt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_flag && !evt_clr |=> evt_flag);

  assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status == 2'd3 && !kill |=> status == 2'd3 && abort);

  assert_abort_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !mreq_valid);

  assert_kill_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> status == 2'd0 && !mreq_valid && !abort);

  assert_valid_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> status == 2'd2);
endmodule

bind dma_ucode_channel dma_ucode_channel_chk u_chk (.*);

// File: tb/tb_dma_ucode_channel.sv
module tb_dma_ucode_channel;
  localparam int CLK_PERIOD = 10;
  localparam int PAW = 8;

  logic clk = 0, rst_n = 0;
  logic pm_we = 0, start = 0, kill = 0, evt_clr = 0, mreq_ready = 0;
  logic [PAW-1:0] pm_waddr = '0, start_pc = '0;
  logic [7:0] pm_wdata = '0;
  logic mreq_valid, mreq_write, evt_flag, abort;
  logic [31:0] mreq_addr;
  logic [3:0] mreq_beats_m1;
  logic [2:0] mreq_size;
  logic [1:0] status;
  logic [7:0] evt_id;

  int checks = 0, failures = 0, cycles = 0, req_cnt = 0;
  int resp_mode = 0;
  logic [31:0] e_sar, e_dar, e_ccr;
  logic e_wr;

  dma_ucode_channel #(.PAW(PAW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] step(input logic [3:0] bm1, input logic [2:0] sz);
    return ({28'd0, bm1} + 32'd1) << sz;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (mreq_valid && resp_mode == 0) mreq_ready = ($urandom % 2) == 0;
    else mreq_ready = 1'b0;
    if (mreq_valid && mreq_ready) begin
      req_cnt++;
      if (!e_wr)
        chk(!mreq_write && mreq_addr == e_sar && mreq_beats_m1 == e_ccr[7:4] &&
            mreq_size == e_ccr[3:1], "R5", "load request",
            {mreq_write, mreq_addr}, {1'b0, e_sar});
      else
        chk(mreq_write && mreq_addr == e_dar && mreq_beats_m1 == e_ccr[21:18] &&
            mreq_size == e_ccr[17:15], "R6", "store request",
            {mreq_write, mreq_addr}, {1'b1, e_dar});
      if (!e_wr && e_ccr[0]) e_sar = e_sar + step(e_ccr[7:4], e_ccr[3:1]);
      if (e_wr && e_ccr[14]) e_dar = e_dar + step(e_ccr[21:18], e_ccr[17:15]);
      e_wr = ~e_wr;
    end
  end

  task automatic wb(input int a, input logic [7:0] d);
    @(negedge clk);
    pm_we = 1; pm_waddr = PAW'(a); pm_wdata = d;
    @(negedge clk);
    pm_we = 0;
  endtask

  task automatic wmov(input int a, input logic [7:0] rd, input logic [31:0] v);
    wb(a, 8'hBC); wb(a+1, rd);
    for (int i = 0; i < 4; i++) wb(a+2+i, v[8*i +: 8]);
  endtask

  task automatic pulse_start(input int a);
    @(negedge clk);
    start = 1; start_pc = PAW'(a);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (status != 2'd0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(status == 2'd0, "R7", "program ends idle", status, 0);
  endtask

  task automatic run_loop(input int b, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] c, input logic [7:0] n1,
                          input logic [7:0] n0, input logic [7:0] ev, input bit poke);
    wmov(b, 8'd0, s); wmov(b+6, 8'd2, d); wmov(b+12, 8'd1, c);
    wb(b+18, 8'h22); wb(b+19, n1);
    wb(b+20, 8'h20); wb(b+21, n0);
    wb(b+22, 8'h04); wb(b+23, 8'h08);
    wb(b+24, 8'h38); wb(b+25, 8'd2);
    wb(b+26, 8'h3C); wb(b+27, 8'd6);
    wb(b+28, 8'h34); wb(b+29, ev);
    wb(b+30, 8'h00);
    e_sar = s; e_dar = d; e_ccr = c; e_wr = 0; req_cnt = 0;
    pulse_start(b);
    chk(status == 2'd1, "R11", "executing status", status, 1);
    if (poke) begin
      repeat (30) @(negedge clk);
      pulse_start(250);
    end
    wait_idle();
    chk(req_cnt == 2 * (int'(n0) + 1) * (int'(n1) + 1), "R4", "request count",
        req_cnt, 2 * (int'(n0) + 1) * (int'(n1) + 1));
    chk(evt_flag && evt_id == ev, "R8", "event raised", {evt_flag, evt_id}, {1'b1, ev});
  endtask

  initial begin
    void'($urandom(32'd4711));
    e_wr = 0; e_sar = 0; e_dar = 0; e_ccr = 0;
    repeat (3) @(negedge clk);
    chk(status == 2'd0 && !mreq_valid && !evt_flag && !abort, "R1", "reset state",
        {status, mreq_valid, evt_flag, abort}, 0);
    rst_n = 1;
    wb(250, 8'hFF);

    run_loop(16, 32'h1000_0000, 32'h1100_0000, 32'h001D_C077, 8'd1, 8'd2, 8'h05, 0);
    run_loop(40, 32'h2000_0000, 32'h3000_0000, 32'h0000_4001, 8'd0, 8'hFF, 8'h11, 0);

    for (int k = 0; k < 8; k++) begin
      logic [31:0] c;
      c = {10'd0, 4'($urandom), 3'($urandom), 1'($urandom), 6'd0, 4'($urandom),
           3'($urandom), 1'($urandom)};
      run_loop(($urandom % 200) + 2, $urandom, $urandom, c,
               8'($urandom % 4), 8'($urandom % 4), 8'($urandom), k == 3);
    end

    @(negedge clk); evt_clr = 1;
    @(negedge clk); evt_clr = 0;
    chk(!evt_flag, "R8", "flag cleared", evt_flag, 0);

    wmov(100, 8'd0, 32'hABCD_0000); wb(106, 8'h04); wb(107, 8'h00);
    resp_mode = 1;
    pulse_start(100);
    repeat (12) @(negedge clk);
    chk(status == 2'd2 && mreq_valid && mreq_addr == 32'hABCD_0000 && !mreq_write,
        "R3", "stalled load at loaded source", {status, mreq_valid, mreq_addr},
        {2'd2, 1'b1, 32'hABCD_0000});
    kill = 1; @(negedge clk); kill = 0;
    chk(status == 2'd0 && !mreq_valid, "R10", "kill drops request",
        {status, mreq_valid}, 0);
    resp_mode = 0;

    pulse_start(250);
    repeat (3) @(negedge clk);
    chk(status == 2'd3 && abort, "R9", "undefined opcode faults", {status, abort}, 7);
    pulse_start(16);
    repeat (3) @(negedge clk);
    chk(status == 2'd3 && !mreq_valid, "R9", "start ignored in fault", status, 3);
    kill = 1; @(negedge clk); kill = 0;
    chk(status == 2'd0 && !abort, "R10", "kill clears abort", {status, abort}, 0);

    wmov(120, 8'd3, 32'h1); wb(126, 8'h00);
    pulse_start(120);
    repeat (10) @(negedge clk);
    chk(status == 2'd3, "R3", "bad register select faults", status, 3);
    kill = 1; @(negedge clk); kill = 0;

    wb(130, 8'h34); wb(131, 8'h77); wb(132, 8'h00);
    pulse_start(130);
    repeat (2) @(negedge clk);
    evt_clr = 1; @(negedge clk); evt_clr = 0;
    chk(evt_flag && evt_id == 8'h77, "R8", "event wins over clear", {evt_flag, evt_id},
        {1'b1, 8'h77});
    wait_idle();
    chk(!start && status == 2'd0, "R2", "idle after short program", status, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule